// File: doc/BRIEF.md
# Consecutive-Edge Phase Picker

This block chooses the sampling phase for a receiver that takes several samples of an incoming NRZ line per bit period without recovering a clock. It runs at the bit rate. In every valid cycle it receives one word of `M` oversampled values. It finds the transitions in that word and maps the first one to one of `M` sampling domains. A domain becomes the committed edge position only after `W` edges in a row have landed in it. Cycles that contain no transition do not count toward such a run and do not break it.

When a run completes, the block loads a new sampling phase. That phase sits about half a bit away from the edge domain, so the sample falls near the centre of the eye. On every valid word the block also outputs the sample taken at the phase in force, together with a valid strobe. A small controller has two states. `ST_SEEK` is entered from reset and means no decision has been made yet. `ST_HOLD` means a phase has been committed. There is one transition, `SEEK_TO_HOLD`, taken on the first decision. `ST_HOLD` stays in place, and further decisions only reload the phase. Only reset leaves `ST_HOLD`.

Top module: `cedge_phase_picker`

## Requirements
- R1: While reset (`rst_n` low) is applied and right after it, `phase_o` is 0 and `lock_o`, `decide_o` and `bit_vld_o` are 0.
- R2: `bit_vld_o` equals `samp_vld_i` of the previous cycle. A word presented with `samp_vld_i` low has no effect on any later output.
- R3: Bit j of `samp_i` is the j-th sample in time, with bit 0 the earliest. For each valid word, `bit_o` one cycle later equals `samp_i[p]`, where p is the phase in force before that word.
- R4: Domain i (1..M-1) holds an edge when sample i differs from sample i-1. Domain 0 holds an edge when sample 0 differs from the last sample of the previous valid word. The first valid word after reset has no edge.
- R5: When a word has several transitions, only the lowest-numbered edge domain counts.
- R6: The W-th consecutive edge in domain i makes `decide_o` 1 in the output cycle of that word. `phase_o` then becomes (i + (M+1)/2) mod M. With the default M=5, W=3 this is (i+3) mod 5.
- R7: An edge in any other domain restarts the run of domain i.
- R8: Valid words without any transition neither advance nor break a run.
- R9: After a decision every run is cleared, so the next decision needs W fresh edges.
- R10: `lock_o` rises with the first decision (`SEEK_TO_HOLD`) and stays high until reset.
- R11: `phase_o` changes only in a cycle in which `decide_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock (zero-phase sampling clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_vld_i | input | 1 | Oversampled word is valid this cycle |
| samp_i | input | M | Oversampled word, bit 0 earliest |
| bit_o | output | 1 | Recovered bit at the current phase |
| bit_vld_o | output | 1 | `bit_o` is valid |
| decide_o | output | 1 | A new phase decision was taken on this word |
| phase_o | output | $clog2(M) | Sampling phase in force |
| lock_o | output | 1 | At least one decision since reset |

## Verification
A run register that misses a clear or a shift shows up at the ports as a `decide_o` pulse on the wrong edge, early or late by at least one word. The bench catches it at that word's output cycle, one clock after the word, because it predicts the exact word that completes each run. A wrong edge-domain priority or a wrong domain-0 reference leads to a wrong `phase_o` at the next decision. `bit_o` then diverges from the expected sample on the very next valid word. The stimulus walks the edge position across every domain with gaps and invalid words between edges, so drift, restarts and holds are all seen.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

    typedef enum logic {
        ST_SEEK = 1'b0,
        ST_HOLD = 1'b1
    } pick_state_e;

endpackage

// File: rtl/cpp_edge_finder.sv
module cpp_edge_finder #(
    parameter int M = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [M-1:0] samp_i,
    output logic [M-1:0] edge_oh_o
);
    logic         last_q;
    logic         primed_q;
    logic [M-1:0] prev_w;
    logic [M-1:0] raw_w;

    // each sample compared with its predecessor in time
    always_comb begin
        prev_w = {samp_i[M-2:0], last_q};
        raw_w  = samp_i ^ prev_w;
        if (vld_i && primed_q)
            edge_oh_o = raw_w & (~raw_w + M'(1));
        else
            edge_oh_o = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q   <= 1'b0;
            primed_q <= 1'b0;
        end else if (vld_i) begin
            last_q   <= samp_i[M-1];
            primed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/cpp_domain_chain.sv
module cpp_domain_chain #(
    parameter int W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic clr_i,
    output logic hit_o
);
    generate
        if (W == 1) begin : g_single
            assign hit_o = adv_i;
        end else begin : g_chain
            localparam int SW = W - 1;
            logic [SW-1:0] sr_q;

            assign hit_o = adv_i && sr_q[SW-1];

            always_ff @(posedge clk) begin
                if (!rst_n)
                    sr_q <= '0;
                else if (clr_i)
                    sr_q <= '0;
                else if (adv_i)
                    sr_q <= SW'({sr_q, 1'b1});
            end
        end
    endgenerate
endmodule

// File: rtl/cedge_phase_picker.sv
module cedge_phase_picker #(
    parameter int M = 5,
    parameter int W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 samp_vld_i,
    input  logic [M-1:0]         samp_i,
    output logic                 bit_o,
    output logic                 bit_vld_o,
    output logic                 decide_o,
    output logic [$clog2(M)-1:0] phase_o,
    output logic                 lock_o
);
    import cpp_pkg::*;

    localparam int PW   = $clog2(M);
    localparam int HALF = (M + 1) / 2;

    logic [M-1:0]  edge_oh;
    logic [M-1:0]  hit_v;
    logic          flush;
    logic [PW-1:0] hit_idx;
    logic [PW-1:0] new_phase;
    logic [PW-1:0] phase_q;
    pick_state_e   state_q, state_d;

    cpp_edge_finder #(.M(M)) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (samp_vld_i),
        .samp_i   (samp_i),
        .edge_oh_o(edge_oh)
    );

    assign flush = |hit_v;

    generate
        for (genvar i = 0; i < M; i++) begin : g_dom
            localparam logic [M-1:0] SELF = M'(1) << i;
            logic others;
            assign others = |(edge_oh & ~SELF);
            cpp_domain_chain #(.W(W)) u_chain (
                .clk  (clk),
                .rst_n(rst_n),
                .adv_i(edge_oh[i]),
                .clr_i(others | flush),
                .hit_o(hit_v[i])
            );
        end
    endgenerate

    always_comb begin
        hit_idx = '0;
        for (int k = 0; k < M; k++)
            if (hit_v[k]) hit_idx = PW'(k);
        new_phase = PW'((32'(hit_idx) + HALF) % M);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK: if (flush) state_d = ST_HOLD;   // SEEK_TO_HOLD
            ST_HOLD: state_d = ST_HOLD;
            default: state_d = ST_SEEK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_SEEK;
        else
            state_q <= state_d;
    end

    // outputs and phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_o     <= 1'b0;
            bit_vld_o <= 1'b0;
            decide_o  <= 1'b0;
            phase_q   <= '0;
        end else begin
            bit_vld_o <= samp_vld_i;
            decide_o  <= flush;
            if (samp_vld_i)
                bit_o <= samp_i[phase_q];
            if (flush)
                phase_q <= new_phase;
        end
    end

    assign phase_o = phase_q;
    assign lock_o  = (state_q == ST_HOLD);
endmodule

// File: rtl/cedge_phase_picker_chk.sv
module cedge_phase_picker_chk #(
    parameter int M = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 samp_vld_i,
    input logic                 bit_vld_o,
    input logic                 decide_o,
    input logic [$clog2(M)-1:0] phase_o,
    input logic                 lock_o
);
    assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld_i |=> bit_vld_o);
    assert_vld_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_vld_i |=> !bit_vld_o);
    assert_decide_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        decide_o |-> bit_vld_o);
    assert_decide_locks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        decide_o |-> lock_o);
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);
    assert_phase_moves_on_decide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_o) |-> decide_o);
    assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(phase_o) < M);
endmodule

bind cedge_phase_picker cedge_phase_picker_chk #(.M(M)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_vld_i(samp_vld_i),
    .bit_vld_o (bit_vld_o),
    .decide_o  (decide_o),
    .phase_o   (phase_o),
    .lock_o    (lock_o)
);

// File: tb/cedge_phase_picker_tb.sv
module cedge_phase_picker_tb_top;
    localparam int M = 5;
    localparam int W = 3;
    localparam int PW = $clog2(M);
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          samp_vld_i = 1'b0;
    logic [M-1:0]  samp_i = '0;
    logic          bit_o, bit_vld_o, decide_o, lock_o;
    logic [PW-1:0] phase_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic  b;
        logic  d;
        int    ph;
        logic  lk;
        string tag;
    } exp_t;
    exp_t q[$];

    // reference model state
    int   cnt [M];
    logic mlast   = 1'b0;
    bit   mprimed = 0;
    int   mphase  = 0;
    logic mlock   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cedge_phase_picker #(.M(M), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .samp_vld_i(samp_vld_i), .samp_i(samp_i),
        .bit_o(bit_o), .bit_vld_o(bit_vld_o), .decide_o(decide_o),
        .phase_o(phase_o), .lock_o(lock_o)
    );

    task automatic check(bit ok, string req, string what, int got, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic send_word(logic [M-1:0] w, string tag);
        exp_t e;
        int   dom;
        logic dec;
        @(negedge clk);
        samp_i = w;
        samp_vld_i = 1'b1;
        e.b = w[mphase];
        dom = -1;
        if (mprimed) begin
            for (int i = 0; i < M; i++) begin
                logic pv;
                pv = (i == 0) ? mlast : w[i-1];
                if (dom < 0 && w[i] != pv) dom = i;
            end
        end
        dec = 1'b0;
        if (dom >= 0) begin
            for (int i = 0; i < M; i++) if (i != dom) cnt[i] = 0;
            cnt[dom]++;
            if (cnt[dom] == W) begin
                dec = 1'b1;
                mphase = (dom + (M + 1) / 2) % M;
                mlock = 1'b1;
                for (int i = 0; i < M; i++) cnt[i] = 0;
            end
        end
        mprimed = 1;
        mlast = w[M-1];
        e.d = dec;
        e.ph = mphase;
        e.lk = mlock;
        e.tag = tag;
        q.push_back(e);
    endtask

    // bit b with its transition placed at domain p
    task automatic send_bit(logic b, int p, string tag);
        logic [M-1:0] w;
        for (int j = 0; j < M; j++) w[j] = (j < p) ? mlast : b;
        send_word(w, tag);
    endtask

    task automatic send_idle(logic [M-1:0] junk);
        @(negedge clk);
        samp_i = junk;
        samp_vld_i = 1'b0;
        @(negedge clk);
        check(bit_vld_o == 1'b0, "R2", "bit_vld after idle", int'(bit_vld_o), 0);
        check(int'(phase_o) == mphase, "R2", "phase after idle", int'(phase_o), mphase);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && bit_vld_o) begin
            if (q.size() == 0) begin
                check(0, "R2", "unexpected bit_vld", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(bit_o === e.b, "R3", {e.tag, " bit"}, int'(bit_o), int'(e.b));
                check(decide_o === e.d, e.tag, "decide", int'(decide_o), int'(e.d));
                check(int'(phase_o) == e.ph, "R11", {e.tag, " phase"}, int'(phase_o), e.ph);
                check(lock_o === e.lk, "R10", {e.tag, " lock"}, int'(lock_o), int'(e.lk));
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < M; i++) cnt[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(phase_o == '0, "R1", "phase in reset", int'(phase_o), 0);
        check(lock_o == 1'b0, "R1", "lock in reset", int'(lock_o), 0);
        check(decide_o == 1'b0, "R1", "decide in reset", int'(decide_o), 0);
        check(bit_vld_o == 1'b0, "R1", "bit_vld in reset", int'(bit_vld_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(phase_o == '0 && lock_o == 1'b0, "R1", "after reset", int'(lock_o), 0);

        // R4: first word never shows an edge even though line was 0
        send_word(5'b11111, "R4");
        // R6/R8: two edges at domain 3, gaps, then third edge decides
        send_bit(1'b0, 3, "R6");
        send_bit(1'b1, 3, "R6");
        send_idle(5'b01010);
        send_word(5'b11111, "R8");
        send_word(5'b11111, "R8");
        send_bit(1'b0, 3, "R6");
        // R7: run in domain 4 broken by domain 1
        send_bit(1'b1, 4, "R7");
        send_bit(1'b0, 4, "R7");
        send_bit(1'b1, 1, "R7");
        send_bit(1'b0, 4, "R7");
        send_bit(1'b1, 4, "R7");
        send_bit(1'b0, 4, "R7");
        // R9: runs cleared after decision
        send_bit(1'b1, 4, "R9");
        send_bit(1'b0, 4, "R9");
        send_bit(1'b1, 4, "R9");
        // R5: two transitions per word, lowest domain (1) counts
        send_word(5'b11001, "R5");
        send_word(5'b11001, "R5");
        send_word(5'b11001, "R5");
        // R4: domain 0 edges against previous word's last sample
        send_bit(1'b0, 0, "R4");
        send_idle(5'b11111);
        send_bit(1'b1, 0, "R4");
        send_bit(1'b0, 0, "R4");
        // drifting pattern across all domains
        lfsr = 16'hACE1;
        for (int k = 0; k < 120; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(lfsr[0], (k / 9) % M, "R6");
            if (k % 17 == 5) send_idle(5'b10101);
        end
        send_idle(5'b00000);
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R2", "queue drained", q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule